// File: doc/BRIEF.md
# Shared-Bus Arbiter with Atomic Lock Line and Spin-Lock Acquirers

This block lets several CPU-side agents share one memory bus and acquire software lock words on it without races. A round-robin arbiter hands out the bus one cycle at a time. A granted master may raise a lock line alongside its request. While that line is high, the arbiter keeps the bus with that master, so a test-and-set's read and write cycles cannot be split by anyone else.

Each master port carries an acquirer engine. A single-cycle `acq_req` pulse starts an acquisition of the lock word at `lock_addr`. The engine first polls the word with plain, unlocked reads. It issues the locked test-and-set only when a poll returns zero. A failed poll or a lost test-and-set puts it into a wait whose length doubles on each failure, up to a ceiling. A `rel_req` pulse writes zero to the word. Both operations end with a one-cycle `op_done` pulse. The memory sits outside the block and answers reads in the same cycle.

Top module: `lb_top`

## Requirements
- R1: At most one master is granted per cycle, and only a master that is requesting. After reset no grant, no lock and no write are present.
- R2: A test-and-set is a locked read cycle. It is followed in the very next cycle by a locked write of the value 1 to the same address by the same master.
- R3: During a lock-held read-write pair, no other master receives a grant. Once the lock drops, other masters can be granted again.
- R4: An acquirer begins with unlocked reads. It makes no locked cycle while the polled word reads nonzero.
- R5: When several acquirers race for the same free word, exactly one of them completes the acquisition and the word ends at 1.
- R6: After the k-th consecutive failure (k=1,2,…), an acquirer waits min(2^(k-1), MAX_WAIT) idle cycles. With the bus otherwise idle, consecutive poll grants are therefore spaced 2, 3, 5, 9, 17, 33, 65, 65, … cycles apart for MAX_WAIT=64.
- R7: A successful acquisition restores the wait length to 1 for the next contention.
- R8: A release writes 0 to the lock word in one granted cycle and pulses `op_done` for that master.
- R9: Unlocked requests are served round-robin. Masters requesting together are each granted for one cycle, in cyclically increasing index order.
- R10: An acquisition succeeds when the test-and-set reads 0. The master's `op_done` then pulses and the word holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | N_MASTERS | Per-master pulse: start acquiring the lock word |
| rel_req | input | N_MASTERS | Per-master pulse: release the lock word |
| lock_addr | input | N_MASTERS*AW | Per-master lock word address, master i at bits [i*AW +: AW] |
| op_done | output | N_MASTERS | Per-master one-cycle completion pulse |
| bus_gnt | output | N_MASTERS | One-hot bus grant |
| bus_lock | output | 1 | Lock line of the granted master |
| mem_addr | output | AW | Bus address |
| mem_we | output | 1 | Bus write enable |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Same-cycle read data from memory |

## Verification
The hardest case to reach is a genuine race. Two acquirers must both see the word free before either one's test-and-set lands. The bench starts two masters in the same cycle on a free word, so their polls are interleaved by round-robin and both take the locked path. Only the locked read then separates the winner from the loser. The doubling wait is measured from poll grant spacing while another master holds the word. The same measurement is repeated after a successful acquisition to show that the wait length has been reset.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_TAS_RD,
    ST_TAS_WR,
    ST_WAIT,
    ST_REL
  } lb_state_e;

  // Doubled wait length, saturated at the ceiling.
  function automatic int unsigned lb_next_backoff(input int unsigned cur,
                                                  input int unsigned cap);
    int unsigned dbl;
    dbl = cur << 1;
    return (dbl > cap) ? cap : dbl;
  endfunction

endpackage

// File: rtl/lb_arbiter.sv
module lb_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] lock,
  output logic [N-1:0] gnt,
  output logic         hold_act
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          hold_q;
  logic [IW-1:0] hold_id_q;
  logic [IW-1:0] rr_q;
  logic [IW-1:0] win;
  logic          found;
  logic [IW-1:0] gid;

  // First requester after the last winner, cyclically.
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(rr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
  end

  assign hold_act = hold_q && lock[hold_id_q];
  assign gid      = hold_act ? hold_id_q : win;

  always_comb begin
    gnt = '0;
    if (hold_act) gnt[hold_id_q] = req[hold_id_q];
    else if (found) gnt[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_id_q <= '0;
      rr_q      <= IW'(N - 1);
    end else begin
      hold_q    <= (|gnt) && lock[gid];
      hold_id_q <= gid;
      if (!hold_act && found) rr_q <= win;
    end
  end
endmodule

// File: rtl/lb_acquirer.sv
module lb_acquirer
  import lb_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 64,
  localparam int BW      = $clog2(MAX_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_req,
  input  logic          rel_req,
  input  logic [AW-1:0] lock_addr,
  input  logic          gnt,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic          lock,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic [BW-1:0] backoff,
  output logic          attempt_fail
);
  lb_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] delay_q;
  logic [BW-1:0] cnt_q;
  logic          old_q;
  logic          done_q;
  logic          seen_free;

  assign req   = (st_q == ST_POLL) || (st_q == ST_TAS_RD) ||
                 (st_q == ST_TAS_WR) || (st_q == ST_REL);
  assign lock  = (st_q == ST_TAS_RD) || (st_q == ST_TAS_WR);
  assign we    = (st_q == ST_TAS_WR) || (st_q == ST_REL);
  assign wdata = (st_q == ST_TAS_WR) ? DW'(1) : '0;
  assign addr  = addr_q;
  assign done  = done_q;
  assign backoff = delay_q;

  assign seen_free    = (rdata == '0);
  assign attempt_fail = gnt && (((st_q == ST_POLL) && !seen_free) ||
                                ((st_q == ST_TAS_WR) && old_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      delay_q <= BW'(1);
      cnt_q   <= '0;
      old_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (attempt_fail) begin
        cnt_q   <= delay_q;
        delay_q <= BW'(lb_next_backoff(32'(delay_q), MAX_WAIT));
        st_q    <= ST_WAIT;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (acq_req) begin
              addr_q <= lock_addr;
              st_q   <= ST_POLL;
            end else if (rel_req) begin
              addr_q <= lock_addr;
              st_q   <= ST_REL;
            end
          end
          ST_POLL:   if (gnt) st_q <= ST_TAS_RD;
          ST_TAS_RD: if (gnt) begin
            old_q <= !seen_free;
            st_q  <= ST_TAS_WR;
          end
          ST_TAS_WR: if (gnt) begin
            delay_q <= BW'(1);
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end
          ST_WAIT: begin
            if (cnt_q <= BW'(1)) st_q <= ST_POLL;
            else cnt_q <= cnt_q - BW'(1);
          end
          ST_REL: if (gnt) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lb_top.sv
module lb_top #(
  parameter int N_MASTERS = 4,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int MAX_WAIT  = 64,
  localparam int BW       = $clog2(MAX_WAIT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MASTERS-1:0]    acq_req,
  input  logic [N_MASTERS-1:0]    rel_req,
  input  logic [N_MASTERS*AW-1:0] lock_addr,
  output logic [N_MASTERS-1:0]    op_done,
  output logic [N_MASTERS-1:0]    bus_gnt,
  output logic                    bus_lock,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_we,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata
);
  logic [N_MASTERS-1:0]    req_vec;
  logic [N_MASTERS-1:0]    lock_vec;
  logic [N_MASTERS-1:0]    we_vec;
  logic [N_MASTERS-1:0]    fail_vec;
  logic [N_MASTERS*BW-1:0] backoff_flat;
  logic [AW-1:0]           addr_w  [N_MASTERS];
  logic [DW-1:0]           wdata_w [N_MASTERS];
  logic                    hold_act;

  lb_arbiter #(.N(N_MASTERS)) arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_vec),
    .lock     (lock_vec),
    .gnt      (bus_gnt),
    .hold_act (hold_act)
  );

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_acq
    lb_acquirer #(.AW(AW), .DW(DW), .MAX_WAIT(MAX_WAIT)) acq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .acq_req      (acq_req[i]),
      .rel_req      (rel_req[i]),
      .lock_addr    (lock_addr[i*AW +: AW]),
      .gnt          (bus_gnt[i]),
      .rdata        (mem_rdata),
      .req          (req_vec[i]),
      .lock         (lock_vec[i]),
      .we           (we_vec[i]),
      .wdata        (wdata_w[i]),
      .addr         (addr_w[i]),
      .done         (op_done[i]),
      .backoff      (backoff_flat[i*BW +: BW]),
      .attempt_fail (fail_vec[i])
    );
  end

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (bus_gnt[i]) begin
        mem_addr  = addr_w[i];
        mem_we    = we_vec[i];
        mem_wdata = wdata_w[i];
      end
    end
  end

  assign bus_lock = |(bus_gnt & lock_vec);
endmodule

// File: rtl/lb_top_chk.sv
module lb_top_chk #(
  parameter int N        = 4,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 64,
  parameter int BW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  gnt,
  input logic [N-1:0]  req,
  input logic          bus_lock,
  input logic          hold_act,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic [N*BW-1:0] backoff_flat
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r1_gnt_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  a_r2_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !mem_we) |=> (bus_lock && mem_we && gnt == $past(gnt) &&
                                mem_addr == $past(mem_addr)));

  a_r2_writes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && mem_we) |-> (mem_wdata == DW'(1)));

  a_r3_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !mem_we) |=> ((gnt & ~$past(gnt)) == '0));

  a_r3_hold_matches_line: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> bus_lock);

  for (genvar i = 0; i < N; i++) begin : g_bo
    a_r6_wait_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (backoff_flat[i*BW +: BW] >= BW'(1)) &&
      (backoff_flat[i*BW +: BW] <= BW'(MAX_WAIT)));
  end
endmodule

bind lb_top lb_top_chk #(
  .N(N_MASTERS), .AW(AW), .DW(DW), .MAX_WAIT(MAX_WAIT), .BW(BW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .gnt          (bus_gnt),
  .req          (req_vec),
  .bus_lock     (bus_lock),
  .hold_act     (hold_act),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .mem_wdata    (mem_wdata),
  .backoff_flat (backoff_flat)
);

// File: tb/lb_top_tb_top.sv
module lb_top_tb_top;
  localparam int N = 4, AW = 8, DW = 8, MW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] acq_req = '0, rel_req = '0;
  logic [N*AW-1:0] lock_addr = '0;
  logic [N-1:0] op_done, bus_gnt;
  logic bus_lock, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] mem [256];

  always #5 clk = ~clk;

  lb_top #(.N_MASTERS(N), .AW(AW), .DW(DW), .MAX_WAIT(MW)) dut_i (.*);

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int done_cnt [N];
  int lock_cnt [N];
  int pw = 0, poll_n = 0;
  int poll_t [16];
  int pair_err = 0;
  int last_w0 = -1;
  logic prev_rd = 1'b0;
  logic [N-1:0] prev_g = '0;

  initial for (int i = 0; i < N; i++) begin done_cnt[i] = 0; lock_cnt[i] = 0; end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (op_done[i]) done_cnt[i]++;
        if (bus_gnt[i] && bus_lock) lock_cnt[i]++;
      end
      if (bus_gnt[pw] && !bus_lock && !mem_we && poll_n < 16) begin
        poll_t[poll_n] = cyc;
        poll_n++;
      end
      if (bus_gnt[0] && mem_we) last_w0 = int'(mem_wdata);
      if (prev_rd && !(bus_lock && mem_we && bus_gnt == prev_g)) pair_err++;
      prev_rd = bus_lock && !mem_we;
      prev_g  = bus_gnt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_addr(input int m, input int a);
    lock_addr[m*AW +: AW] = AW'(a);
  endtask

  task automatic pulse(input logic [N-1:0] acq, input logic [N-1:0] rel);
    @(negedge clk);
    acq_req = acq; rel_req = rel;
    @(negedge clk);
    acq_req = '0; rel_req = '0;
  endtask

  task automatic wait_done(input int m, input int base, input int lim);
    for (int k = 0; k < lim && done_cnt[m] == base; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(bus_gnt == '0, "R1 reset grant", int'(bus_gnt), 0);
    chk(!bus_lock && !mem_we, "R1 reset lock/we", int'({bus_lock, mem_we}), 0);
    chk(op_done == '0, "R1 reset done", int'(op_done), 0);
  endtask

  task automatic t_single;
    int b;
    b = done_cnt[0];
    set_addr(0, 'h10);
    pulse(4'b0001, 4'b0000);
    wait_done(0, b, 50);
    chk(done_cnt[0] == b + 1, "R10 acquire done", done_cnt[0] - b, 1);
    chk(mem['h10] == 1, "R10 word set", int'(mem['h10]), 1);
    chk(lock_cnt[0] == 2, "R2 two locked cycles", lock_cnt[0], 2);
  endtask

  task automatic t_backoff;
    int exp_gap [9] = '{2, 3, 5, 9, 17, 33, 65, 65, 65};
    int lc;
    lc = lock_cnt[1];
    pw = 1; poll_n = 0;
    set_addr(1, 'h10);
    pulse(4'b0010, 4'b0000);
    for (int k = 0; k < 1000 && poll_n < 10; k++) @(negedge clk);
    chk(poll_n >= 10, "R6 poll count", poll_n, 10);
    for (int k = 0; k < 9; k++)
      chk(poll_t[k+1] - poll_t[k] == exp_gap[k], "R6 poll gap",
          poll_t[k+1] - poll_t[k], exp_gap[k]);
    chk(lock_cnt[1] == lc, "R4 no locked cycle while held", lock_cnt[1] - lc, 0);
  endtask

  task automatic t_handoff;
    int b0, b1;
    b0 = done_cnt[0]; b1 = done_cnt[1];
    set_addr(0, 'h10);
    pulse(4'b0000, 4'b0001);
    wait_done(0, b0, 20);
    chk(done_cnt[0] == b0 + 1, "R8 release done", done_cnt[0] - b0, 1);
    chk(last_w0 == 0, "R8 release writes zero", last_w0, 0);
    wait_done(1, b1, 100);
    chk(done_cnt[1] == b1 + 1, "R10 waiter acquires", done_cnt[1] - b1, 1);
    chk(mem['h10] == 1, "R10 word held", int'(mem['h10]), 1);
    b1 = done_cnt[1];
    pulse(4'b0000, 4'b0010);
    wait_done(1, b1, 20);
    b0 = done_cnt[0];
    pulse(4'b0001, 4'b0000);
    wait_done(0, b0, 20);
    pw = 1; poll_n = 0;
    pulse(4'b0010, 4'b0000);
    for (int k = 0; k < 100 && poll_n < 3; k++) @(negedge clk);
    chk(poll_t[1] - poll_t[0] == 2, "R7 wait restarts at 1", poll_t[1] - poll_t[0], 2);
    chk(poll_t[2] - poll_t[1] == 3, "R7 wait doubles again", poll_t[2] - poll_t[1], 3);
    b1 = done_cnt[1]; b0 = done_cnt[0];
    pulse(4'b0000, 4'b0001);
    wait_done(1, b1, 100);
    b1 = done_cnt[1];
    pulse(4'b0000, 4'b0010);
    wait_done(1, b1, 20);
    chk(mem['h10] == 0, "R8 word cleared", int'(mem['h10]), 0);
  endtask

  task automatic t_race;
    int b2, b3, w, l, bl;
    b2 = done_cnt[2]; b3 = done_cnt[3];
    set_addr(2, 'h20); set_addr(3, 'h20);
    pulse(4'b1100, 4'b0000);
    repeat (20) @(negedge clk);
    chk((done_cnt[2] - b2) + (done_cnt[3] - b3) == 1, "R5 one winner",
        (done_cnt[2] - b2) + (done_cnt[3] - b3), 1);
    chk(mem['h20] == 1, "R5 word set", int'(mem['h20]), 1);
    chk(pair_err == 0, "R3 pair not split", pair_err, 0);
    w = (done_cnt[2] != b2) ? 2 : 3;
    l = 5 - w;
    bl = done_cnt[l];
    pulse(4'b0000, 4'(1 << w));
    wait_done(l, bl, 100);
    chk(done_cnt[l] == bl + 1, "R5 loser gets it after release", done_cnt[l] - bl, 1);
    bl = done_cnt[l];
    pulse(4'b0000, 4'(1 << l));
    wait_done(l, bl, 20);
  endtask

  task automatic t_rr;
    int g [8];
    int first, b2;
    set_addr(0, 'h30); set_addr(1, 'h31); set_addr(2, 'h32);
    pulse(4'b0111, 4'b0000);
    repeat (20) @(negedge clk);
    b2 = done_cnt[2];
    @(negedge clk);
    rel_req = 4'b0111;
    @(negedge clk);
    rel_req = '0;
    for (int k = 0; k < 8; k++) begin
      g[k] = -1;
      for (int i = 0; i < N; i++) if (bus_gnt[i]) g[k] = i;
      @(negedge clk);
    end
    first = -1;
    for (int k = 0; k < 6; k++) if (first < 0 && g[k] >= 0) first = k;
    chk(first >= 0, "R9 grants seen", first, 0);
    if (first >= 0) begin
      chk(g[first+1] == (g[first] + 1) % 3, "R9 cyclic order 1", g[first+1], (g[first] + 1) % 3);
      chk(g[first+2] == (g[first] + 2) % 3, "R9 cyclic order 2", g[first+2], (g[first] + 2) % 3);
    end
    chk(done_cnt[2] == b2 + 1, "R8 release done m2", done_cnt[2] - b2, 1);
    chk(mem['h30] == 0 && mem['h31] == 0 && mem['h32] == 0, "R8 words cleared",
        int'(mem['h30]) + int'(mem['h31]) + int'(mem['h32]), 0);
    chk(pair_err == 0, "R3 pair not split", pair_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_backoff();
    t_handoff();
    t_race();
    t_rr();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule